// File: doc/BRIEF.md
# Serial Receive Path with Line-Error Flags

This block takes an asynchronous serial line, recovers characters from it using an oversampling tick, and hands each assembled byte to the surrounding logic with a single-cycle strobe. While it decodes frames, it watches the line for three faults: a stop bit that reads low, an even-parity mismatch when parity is switched on, and a line held low for longer than a whole frame. Each fault sets a sticky flag that software clears by writing a one to that bit.

A small register port gives access to two registers. The first is a 4-bit on/off field that reads back the value last written. The receiver runs only while this field holds the code 4. Any other code holds the receiver and the long-low detector in their idle state. The second register holds the error flags. Parity checking is chosen by a configuration input, and that input also sets the frame length that the long-low detector compares against.

Top module: `uart_rx_lineerr`

## Requirements
- R1: After reset, the on/off register reads 0, the error register reads 0 and no byte strobe occurs.
- R2: The receiver decodes frames only while the on/off register holds 4. With any other value (0 to 15, except 4), no byte strobe occurs and no error flag is set.
- R3: Each bit lasts 16 baud ticks and is sampled near its middle. The start bit is confirmed 8 ticks after the first low tick, and a start bit that is high again by then is discarded. The 8 data bits arrive least significant bit first.
- R4: Every decoded frame gives exactly one `rx_valid` pulse, one clock wide, with the byte on `rx_data` in the same cycle. This happens whether or not an error was found.
- R5: With `parity_en` high, a parity bit follows the data and even parity is checked. A mismatch sets error bit 1. With `parity_en` low, no parity bit is expected.
- R6: A stop bit sampled low sets error bit 0, and the byte is still delivered.
- R7: Error bit 2 is set when the line has been low for more than 160 consecutive ticks with parity off, or more than 176 with parity on. It is set at most once per low period, so clearing it while the line stays low leaves it clear.
- R8: The error flags (bit 0 framing, bit 1 parity, bit 2 break) stay set until a register write with `reg_sel`=1 puts a 1 in that bit position. Writing a 0 has no effect.
- R9: After a frame whose stop bit was low, the receiver waits for the line to go high before it accepts a new start bit.
- R10: A write with `reg_sel`=0 stores `reg_wdata` into the on/off register, and reading with `reg_sel`=0 returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial data line, idle high |
| parity_en | input | 1 | Enable the even-parity bit |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the on/off register, 1 selects the error register |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for the selected register |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |

## Verification
The assertions check on every cycle that the byte strobe lasts one cycle and follows only a stop-bit sample, that no strobe appears while the receiver is off, that the break pulse fires alone and only while the line is low, and that raised flags persist until cleared. The bench scenarios are needed for the rest: correct byte values across all 256 codes with and without parity, the exact tick counts at which a break is or is not flagged, rejection of short start glitches, waiting for the line to recover after a break, and the full set of on/off codes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;
  localparam int NERR       = 3;
  localparam int ERR_FRAME  = 0;
  localparam int ERR_PARITY = 1;
  localparam int ERR_BREAK  = 2;
  localparam int REG_W      = 4;
  localparam logic [REG_W-1:0] RUN_CODE = 4'd4;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             rxd,
  input  logic             par_en,
  output logic             valid,
  output logic [DBITS-1:0] data,
  output logic             frame_err,
  output logic             par_err
);
  import uart_rx_pkg::*;
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DBITS + 1);
  localparam logic [CW-1:0] MID     = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DBITS - 1);

  rx_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [DBITS-1:0] sh_q, sh_d;
  logic             acc_q, acc_d, pbad_q, pbad_d;
  logic             valid_q, valid_d, ferr_q, ferr_d, perr_q, perr_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    acc_d   = acc_q;
    pbad_d  = pbad_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    perr_d  = 1'b0;
    if (!active) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: if (!rxd) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
        ST_START: if (cnt_q == MID) begin
          cnt_d  = '0;
          bit_d  = '0;
          acc_d  = 1'b0;
          pbad_d = 1'b0;
          state_d = rxd ? ST_IDLE : ST_DATA;
        end else cnt_d = cnt_q + 1'b1;
        ST_DATA: if (cnt_q == LAST) begin
          cnt_d = '0;
          sh_d  = {rxd, sh_q[DBITS-1:1]};
          acc_d = acc_q ^ rxd;
          if (bit_q == LASTBIT) state_d = par_en ? ST_PAR : ST_STOP;
          else bit_d = bit_q + 1'b1;
        end else cnt_d = cnt_q + 1'b1;
        ST_PAR: if (cnt_q == LAST) begin
          cnt_d   = '0;
          pbad_d  = acc_q ^ rxd;
          state_d = ST_STOP;
        end else cnt_d = cnt_q + 1'b1;
        ST_STOP: if (cnt_q == LAST) begin
          cnt_d   = '0;
          valid_d = 1'b1;
          ferr_d  = !rxd;
          perr_d  = pbad_q;
          state_d = rxd ? ST_IDLE : ST_HOLD;
        end else cnt_d = cnt_q + 1'b1;
        ST_HOLD: if (rxd) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      pbad_q  <= 1'b0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      acc_q   <= acc_d;
      pbad_q  <= pbad_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
      perr_q  <= perr_d;
    end
  end

  assign valid     = valid_q;
  assign data      = sh_q;
  assign frame_err = ferr_q;
  assign par_err   = perr_q;

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_strobe_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(state_q) == ST_STOP);
  assert_errs_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_q || perr_q) |-> valid_q);
endmodule

// File: rtl/uart_rx_break_det.sv
module uart_rx_break_det #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic rxd,
  input  logic par_en,
  output logic brk
);
  localparam int LIM_NP = (DBITS + 2) * OVS;
  localparam int LIM_P  = (DBITS + 3) * OVS;
  localparam int BW     = $clog2(LIM_P + 2);

  logic [BW-1:0] cnt_q, cnt_d, lim;
  logic          brk_q, brk_d;

  always_comb begin
    lim   = par_en ? BW'(LIM_P) : BW'(LIM_NP);
    cnt_d = cnt_q;
    brk_d = 1'b0;
    if (!active || rxd) cnt_d = '0;
    else if (tick && cnt_q <= lim) begin
      cnt_d = cnt_q + 1'b1;
      brk_d = (cnt_q == lim);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      brk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      brk_q <= brk_d;
    end
  end

  assign brk = brk_q;

  assert_break_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |=> !brk_q);
  assert_break_line_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> $past(!rxd));
endmodule

// File: rtl/uart_rx_errsrc.sv
module uart_rx_errsrc #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q, flags_d;

  always_comb flags_d = (flags_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags_q & $past(set)) == $past(set)));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ~clr)) |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));
endmodule

// File: rtl/uart_rx_lineerr.sv
module uart_rx_lineerr #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             rxd,
  input  logic             parity_en,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [3:0]       reg_wdata,
  output logic [3:0]       reg_rdata,
  output logic             rx_valid,
  output logic [DBITS-1:0] rx_data
);
  import uart_rx_pkg::*;

  logic [REG_W-1:0] en_q, en_d;
  logic             rx_on;
  logic             ferr, perr, brk;
  logic [NERR-1:0]  err_set, err_clr, err_q;

  always_comb begin
    en_d = en_q;
    if (reg_wr && !reg_sel) en_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign rx_on = (en_q == RUN_CODE);

  uart_rx_sampler #(.OVS(OVS), .DBITS(DBITS)) i_sampler (
    .clk(clk), .rst_n(rst_n), .active(rx_on), .tick(baud_tick), .rxd(rxd),
    .par_en(parity_en), .valid(rx_valid), .data(rx_data),
    .frame_err(ferr), .par_err(perr)
  );

  uart_rx_break_det #(.OVS(OVS), .DBITS(DBITS)) i_brk (
    .clk(clk), .rst_n(rst_n), .active(rx_on), .tick(baud_tick), .rxd(rxd),
    .par_en(parity_en), .brk(brk)
  );

  always_comb begin
    err_set             = '0;
    err_set[ERR_FRAME]  = ferr;
    err_set[ERR_PARITY] = perr;
    err_set[ERR_BREAK]  = brk;
    err_clr = (reg_wr && reg_sel) ? reg_wdata[NERR-1:0] : '0;
  end

  uart_rx_errsrc #(.N(NERR)) i_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .flags(err_q)
  );

  always_comb begin
    if (reg_sel) reg_rdata = {{(REG_W-NERR){1'b0}}, err_q};
    else         reg_rdata = en_q;
  end

  assert_off_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> !rx_valid);
  assert_off_no_new_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && $past(!rx_on)) |=> ($countones(err_q) <= $countones($past(err_q))));
endmodule

// File: tb/test_uart_rx_lineerr.sv
module test_uart_rx_lineerr;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 16;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1, parity_en = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [3:0] reg_wdata = 4'd0;
  logic [3:0] reg_rdata;
  logic rx_valid;
  logic [7:0] rx_data;

  int nchk = 0, nfail = 0, nval = 0, dbl = 0, div = 1, tc = 0;
  logic [7:0] last_byte = 8'd0;
  logic prev_v = 1'b0;
  bit done = 0;

  uart_rx_lineerr #(.OVS(OVS), .DBITS(8)) i_uart_rx_lineerr (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .parity_en(parity_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tc + 1 >= div) begin tc = 0; baud_tick = 1'b1; end
    else begin tc = tc + 1; baud_tick = 1'b0; end
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      nval = nval + 1;
      last_byte = rx_data;
      if (prev_v) dbl = dbl + 1;
    end
    prev_v = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic wr(input logic s, input logic [3:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [3:0] v);
    @(negedge clk); reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (OVS * div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit par, input bit flip, input logic stopv);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    if (par) drive_bit((^b) ^ flip);
    drive_bit(stopv);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic hold_low(input int n);
    @(negedge clk); rxd = 1'b0;
    repeat (n) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * OVS) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk(v == 4'd0, "R1 enable reset", v, 0);
    rd(1'b1, v); chk(v == 4'd0, "R1 error reset", v, 0);
    chk(nval == 0, "R1 no strobe", nval, 0);

    // R2 / R10: every code but 4 keeps the receiver off
    for (int c = 0; c < 16; c++) begin
      if (c == 4) continue;
      wr(1'b0, 4'(c));
      rd(1'b0, v); chk(v == 4'(c), "R10 readback", v, c);
      n0 = nval;
      send(8'h55, 1'b0, 1'b0, 1'b0);
      chk(nval == n0, "R2 off no byte", nval, n0);
      rd(1'b1, v); chk(v == 4'd0, "R2 off no error", v, 0);
    end

    wr(1'b0, 4'd4);
    rd(1'b0, v); chk(v == 4'd4, "R10 readback run", v, 4);

    // R3 / R4 sweep, parity off
    for (int b = 0; b < 256; b++) begin
      n0 = nval;
      send(8'(b), 1'b0, 1'b0, 1'b1);
      chk(nval == n0 + 1 && last_byte == 8'(b), "R3 R4 byte no parity", last_byte, b);
    end
    rd(1'b1, v); chk(v == 4'd0, "R3 clean sweep errors", v, 0);

    // R5 sweep, parity on with correct parity
    parity_en = 1'b1;
    for (int b = 0; b < 256; b++) begin
      n0 = nval;
      send(8'(b), 1'b1, 1'b0, 1'b1);
      chk(nval == n0 + 1 && last_byte == 8'(b), "R5 byte with parity", last_byte, b);
    end
    rd(1'b1, v); chk(v == 4'd0, "R5 good parity errors", v, 0);

    // R5 bad parity, R8 write-one-to-clear
    n0 = nval;
    send(8'hA5, 1'b1, 1'b1, 1'b1);
    chk(nval == n0 + 1 && last_byte == 8'hA5, "R5 bad parity byte kept", last_byte, 8'hA5);
    rd(1'b1, v); chk(v == 4'b0010, "R5 parity flag", v, 2);
    wr(1'b1, 4'b0101);
    rd(1'b1, v); chk(v == 4'b0010, "R8 other bits do not clear", v, 2);
    repeat (20) @(negedge clk);
    rd(1'b1, v); chk(v == 4'b0010, "R8 sticky", v, 2);
    wr(1'b1, 4'b0010);
    rd(1'b1, v); chk(v == 4'd0, "R8 cleared", v, 0);
    parity_en = 1'b0;

    // R6 framing error, byte still delivered
    n0 = nval;
    send(8'h3C, 1'b0, 1'b0, 1'b0);
    chk(nval == n0 + 1 && last_byte == 8'h3C, "R6 byte with bad stop", last_byte, 8'h3C);
    rd(1'b1, v); chk(v == 4'b0001, "R6 framing flag", v, 1);
    wr(1'b1, 4'b0001);
    rd(1'b1, v); chk(v == 4'd0, "R8 framing cleared", v, 0);

    // R3 short start glitch rejected
    n0 = nval;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    chk(nval == n0, "R3 glitch rejected", nval, n0);

    // R7 break threshold, parity off (limit 160)
    hold_low(160);
    rd(1'b1, v); chk(v == 4'b0001, "R7 160 low no break", v, 1);
    wr(1'b1, 4'b0111);
    hold_low(161);
    rd(1'b1, v); chk(v == 4'b0101, "R7 161 low break", v, 5);
    wr(1'b1, 4'b0111);

    // R7 parity on (limit 176)
    parity_en = 1'b1;
    hold_low(176);
    rd(1'b1, v); chk(v == 4'b0001, "R7 176 low no break parity", v, 1);
    wr(1'b1, 4'b0111);
    hold_low(177);
    rd(1'b1, v); chk(v == 4'b0101, "R7 177 low break parity", v, 5);
    wr(1'b1, 4'b0111);
    parity_en = 1'b0;

    // R7 once per low period, R9 wait for line high
    n0 = nval;
    @(negedge clk); rxd = 1'b0;
    repeat (250) @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 4'b0111;
    @(negedge clk); reg_wr = 1'b0;
    repeat (300) @(negedge clk);
    #1; v = reg_rdata;
    chk(v == 4'd0, "R7 break not repeated", v, 0);
    chk(nval == n0 + 1, "R9 one frame during long low", nval, n0 + 1);
    rxd = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    chk(nval == n0 + 2 && last_byte == 8'h5A, "R9 recovery byte", last_byte, 8'h5A);

    // R3 slower tick rate
    div = 3;
    repeat (6) @(negedge clk);
    n0 = nval;
    send(8'hC3, 1'b0, 1'b0, 1'b1);
    chk(nval == n0 + 1 && last_byte == 8'hC3, "R3 slow tick byte", last_byte, 8'hC3);
    div = 1;

    chk(dbl == 0, "R4 strobe one cycle", dbl, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule